// File: doc/BRIEF.md
# Nibble-Wide Host Command Interface

This block is the slave end of a narrow host port on a disc-player signal processor. A host reaches it through a four-bit data path, a host-driven strobe clock and an active-low select. All transfers are nibble streams. The block treats the pad as three separate signals: an input nibble, an output nibble and an output enable that controls the tri-state driver. Host clock, select and input nibble are oversampled in the system clock domain. Each passes through a two-flop synchroniser, and the host clock is then edge-detected.

When the select goes low, the block presents a status nibble. The host takes it before its first rising clock edge, and that edge ends the status phase and releases the bus. The next nibble the host sends sets the transaction type. If its top bit is clear, it opens a write. The block collects a command byte and a data byte, high nibble first. One command class collects a third byte. The block then issues a one-cycle register write and answers with a parity nibble. If the top bit is set, it opens a read. The block streams one nibble from a read port on every falling host clock edge until the select returns high. If the select rises before a write is complete, the partial write is dropped.

Top module: `host_nib_if`

## Requirements
- R1: While reset is asserted and on leaving it, `bus_oe`, `wr_en` and `rd_pop` are low.
- R2: After `cs_n` falls, the block drives `status` onto `bus_out` with `bus_oe` high, following its current value. The first rising `hclk` edge releases the bus (`bus_oe` low).
- R3: If the first nibble after the status phase has bit 3 = 0, the transaction is a write. Four nibbles are sampled on rising `hclk` edges: command high, command low, data high, data low. The block then gives exactly one `wr_en` pulse, with `wr_cmd` and `wr_data` holding the bytes and `wr_ext_vld` low.
- R4: If that first nibble equals `EXT_CMD` (default 4'h7), two more nibbles follow the data byte and form `wr_ext` (high nibble first). `wr_en` pulses only after the sixth nibble, with `wr_ext_vld` high.
- R5: On the first falling `hclk` edge after the last write nibble, the block drives the XOR of all nibbles received in that write onto `bus_out`. It holds that value through further host clock edges until `cs_n` rises.
- R6: If the first nibble has bit 3 = 1, the transaction is a read, and `rd_sel` takes bits 2:0 of that nibble. On each later falling `hclk` edge the block drives the current `rd_nib` onto the bus and pulses `rd_pop` for one cycle.
- R7: If `cs_n` rises before the final nibble of a write, the block produces no `wr_en` for that transaction.
- R8: Within five system clocks of `cs_n` rising, `bus_oe` is low.
- R9: While `cs_n` is high, `hclk` edges and bus values produce no `wr_en` and no `rd_pop`, and `bus_oe` stays low.
- R10: During a write, `bus_oe` stays low from the end of the status phase until the parity nibble is driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hclk | input | 1 | Host bus clock (asynchronous) |
| cs_n | input | 1 | Active-low transaction select |
| bus_in | input | 4 | Nibble from the bidirectional pad |
| bus_out | output | 4 | Nibble to the bidirectional pad |
| bus_oe | output | 1 | Pad driver enable |
| status | input | 4 | Status nibble shown during the idle phase |
| wr_en | output | 1 | One-cycle register write strobe |
| wr_cmd | output | 8 | Command byte of the write |
| wr_data | output | 8 | Data byte of the write |
| wr_ext | output | 8 | Extra byte of the extended class |
| wr_ext_vld | output | 1 | The write carried an extra byte |
| rd_sel | output | 3 | Read source selected by the read command |
| rd_nib | input | 4 | Current nibble from the read source |
| rd_pop | output | 1 | Read nibble consumed; source advances |

## Verification
The bench checks the exact nibble at which each write commits. A design that miscounts the extended class would fire its write after four nibbles, or would lose the extra byte. Selects raised after two nibbles, and after five nibbles of an extended write, test abort handling. A design that committed on the select rising, or that kept a stale count, would write a register there. Parity is recomputed from the nibbles sent and checked again after extra host clock edges, which catches a design that overwrites it. The read stream is compared nibble by nibble against a stepping source, which exposes a read port that advances twice per edge or launches on the rising edge.

// File: rtl/hni_pkg.sv
package hni_pkg;
  typedef enum logic [2:0] {
    S_IDLE  = 3'd0,
    S_STAT  = 3'd1,
    S_FIRST = 3'd2,
    S_WR    = 3'd3,
    S_PWAIT = 3'd4,
    S_PAR   = 3'd5,
    S_RD    = 3'd6
  } hni_state_t;
endpackage

// File: rtl/hni_sync.sv
module hni_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST   = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[0] <= RST;
        else        stg[0] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[g] <= RST;
        else        stg[g] <= stg[g-1];
      end
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/hni_fsm.sv
module hni_fsm
  import hni_pkg::*;
#(
  parameter int unsigned NIB = 4,
  parameter logic [NIB-1:0] EXT_CMD = 'h7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel_act,
  input  logic             h_rise,
  input  logic             h_fall,
  input  logic [NIB-1:0]   nib,
  input  logic [NIB-1:0]   status,
  input  logic [NIB-1:0]   rd_nib,
  output logic [NIB-1:0]   bus_out,
  output logic             bus_oe,
  output logic             wr_en,
  output logic [2*NIB-1:0] wr_cmd,
  output logic [2*NIB-1:0] wr_data,
  output logic [2*NIB-1:0] wr_ext,
  output logic             wr_ext_vld,
  output logic [NIB-2:0]   rd_sel,
  output logic             rd_pop
);
  localparam int unsigned BYTE    = 2 * NIB;
  localparam int unsigned MAX_NIB = 6;
  localparam int unsigned SH_W    = MAX_NIB * NIB;
  localparam int unsigned CW      = $clog2(MAX_NIB + 1);
  localparam logic [CW-1:0] LAST_STD = CW'(4);
  localparam logic [CW-1:0] LAST_EXT = CW'(MAX_NIB);

  hni_state_t      st, st_n;
  logic [CW-1:0]   cnt, cnt_n;
  logic [SH_W-1:0] sh, sh_n;
  logic [NIB-1:0]  par, par_n, out_n;
  logic            ext, ext_n, oe_n, wr_n, pop_n;
  logic [NIB-2:0]  sel_n;

  always_comb begin
    st_n  = st;
    cnt_n = cnt;
    sh_n  = sh;
    par_n = par;
    ext_n = ext;
    out_n = bus_out;
    oe_n  = bus_oe;
    sel_n = rd_sel;
    wr_n  = 1'b0;
    pop_n = 1'b0;
    if (!sel_act) begin
      st_n = S_IDLE;
      oe_n = 1'b0;
    end else begin
      unique case (st)
        S_IDLE: begin
          st_n  = S_STAT;
          oe_n  = 1'b1;
          out_n = status;
          cnt_n = '0;
          par_n = '0;
          ext_n = 1'b0;
        end
        S_STAT: begin
          out_n = status;
          if (h_rise) begin
            st_n = S_FIRST;
            oe_n = 1'b0;
          end
        end
        S_FIRST: if (h_rise) begin
          if (nib[NIB-1]) begin
            st_n  = S_RD;
            sel_n = nib[NIB-2:0];
          end else begin
            st_n  = S_WR;
            sh_n  = {{(SH_W-NIB){1'b0}}, nib};
            par_n = nib;
            cnt_n = CW'(1);
            ext_n = (nib == EXT_CMD);
          end
        end
        S_WR: if (h_rise) begin
          sh_n  = {sh[SH_W-NIB-1:0], nib};
          par_n = par ^ nib;
          cnt_n = cnt + 1'b1;
          if (cnt_n == (ext ? LAST_EXT : LAST_STD)) begin
            st_n = S_PWAIT;
            wr_n = 1'b1;
          end
        end
        S_PWAIT: if (h_fall) begin
          st_n  = S_PAR;
          out_n = par;
          oe_n  = 1'b1;
        end
        S_PAR: ;
        S_RD: if (h_fall) begin
          out_n = rd_nib;
          oe_n  = 1'b1;
          pop_n = 1'b1;
        end
        default: st_n = S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      cnt     <= '0;
      sh      <= '0;
      par     <= '0;
      ext     <= 1'b0;
      bus_out <= '0;
      bus_oe  <= 1'b0;
      rd_sel  <= '0;
      wr_en   <= 1'b0;
      rd_pop  <= 1'b0;
    end else begin
      st      <= st_n;
      cnt     <= cnt_n;
      sh      <= sh_n;
      par     <= par_n;
      ext     <= ext_n;
      bus_out <= out_n;
      bus_oe  <= oe_n;
      rd_sel  <= sel_n;
      wr_en   <= wr_n;
      rd_pop  <= pop_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_cmd     <= '0;
      wr_data    <= '0;
      wr_ext     <= '0;
      wr_ext_vld <= 1'b0;
    end else if (wr_n) begin
      wr_cmd     <= ext ? sh_n[3*BYTE-1:2*BYTE] : sh_n[2*BYTE-1:BYTE];
      wr_data    <= ext ? sh_n[2*BYTE-1:BYTE]   : sh_n[BYTE-1:0];
      wr_ext     <= ext ? sh_n[BYTE-1:0]        : '0;
      wr_ext_vld <= ext;
    end
  end
endmodule

// File: rtl/host_nib_if.sv
module host_nib_if #(
  parameter int unsigned NIB = 4,
  parameter int unsigned SYNC_STAGES = 2,
  parameter logic [NIB-1:0] EXT_CMD = 'h7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hclk,
  input  logic             cs_n,
  input  logic [NIB-1:0]   bus_in,
  output logic [NIB-1:0]   bus_out,
  output logic             bus_oe,
  input  logic [NIB-1:0]   status,
  output logic             wr_en,
  output logic [2*NIB-1:0] wr_cmd,
  output logic [2*NIB-1:0] wr_data,
  output logic [2*NIB-1:0] wr_ext,
  output logic             wr_ext_vld,
  output logic [NIB-2:0]   rd_sel,
  input  logic [NIB-1:0]   rd_nib,
  output logic             rd_pop
);
  logic           hclk_s, hclk_d, cs_s;
  logic [NIB-1:0] nib_s;

  hni_sync #(.W(1), .STAGES(SYNC_STAGES), .RST(1'b0)) u_hclk_sync (
    .clk(clk), .rst_n(rst_n), .d(hclk), .q(hclk_s));
  hni_sync #(.W(1), .STAGES(SYNC_STAGES), .RST(1'b1)) u_cs_sync (
    .clk(clk), .rst_n(rst_n), .d(cs_n), .q(cs_s));
  hni_sync #(.W(NIB), .STAGES(SYNC_STAGES), .RST('0)) u_bus_sync (
    .clk(clk), .rst_n(rst_n), .d(bus_in), .q(nib_s));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hclk_d <= 1'b0;
    else        hclk_d <= hclk_s;
  end

  hni_fsm #(.NIB(NIB), .EXT_CMD(EXT_CMD)) u_fsm (
    .clk(clk), .rst_n(rst_n),
    .sel_act(~cs_s),
    .h_rise(hclk_s & ~hclk_d),
    .h_fall(~hclk_s & hclk_d),
    .nib(nib_s), .status(status), .rd_nib(rd_nib),
    .bus_out(bus_out), .bus_oe(bus_oe),
    .wr_en(wr_en), .wr_cmd(wr_cmd), .wr_data(wr_data),
    .wr_ext(wr_ext), .wr_ext_vld(wr_ext_vld),
    .rd_sel(rd_sel), .rd_pop(rd_pop));
endmodule

// File: rtl/hni_chk.sv
module hni_chk #(
  parameter int unsigned NIB = 4,
  parameter int unsigned SYNC_STAGES = 2,
  parameter logic [NIB-1:0] EXT_CMD = 'h7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cs_n,
  input logic [NIB-1:0]   bus_out,
  input logic             bus_oe,
  input logic             wr_en,
  input logic [2*NIB-1:0] wr_cmd,
  input logic             wr_ext_vld,
  input logic [NIB-1:0]   rd_nib,
  input logic             rd_pop
);
  localparam int unsigned HOLD = SYNC_STAGES + 2;
  logic [3:0] hi_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  hi_cnt <= '0;
    else if (!cs_n)              hi_cnt <= '0;
    else if (hi_cnt != 4'hF)     hi_cnt <= hi_cnt + 1'b1;
  end

  always_comb begin
    if (!rst_n) assert_reset_quiet_R1: assert (!bus_oe && !wr_en && !rd_pop);
  end

  assert_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (hi_cnt >= 4'(HOLD)) |-> !bus_oe);

  assert_idle_inert_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (hi_cnt >= 4'(HOLD)) |-> (!wr_en && !rd_pop));

  assert_wr_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !wr_en);

  assert_ext_class_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_ext_vld) |-> (wr_cmd[2*NIB-1:NIB] == EXT_CMD));

  assert_rd_launch_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_pop |-> (bus_oe && bus_out == $past(rd_nib)));

  assert_rd_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_pop |=> !rd_pop);

  assert_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_pop && wr_en));
endmodule

bind host_nib_if hni_chk #(.NIB(NIB), .SYNC_STAGES(SYNC_STAGES), .EXT_CMD(EXT_CMD)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .bus_out(bus_out), .bus_oe(bus_oe),
  .wr_en(wr_en), .wr_cmd(wr_cmd), .wr_ext_vld(wr_ext_vld),
  .rd_nib(rd_nib), .rd_pop(rd_pop));

// File: tb/tb_host_nib_if.sv
module tb_host_nib_if;
  logic       clk = 1'b0, rst_n = 1'b0, hclk = 1'b0, cs_n = 1'b1;
  logic [3:0] bus_in = '0, status = 4'h5, bus_out, rd_nib;
  logic       bus_oe, wr_en, wr_ext_vld, rd_pop;
  logic [7:0] wr_cmd, wr_data, wr_ext;
  logic [2:0] rd_sel;
  int n_chk = 0, n_fail = 0, wr_cnt = 0, pop_cnt = 0;
  logic [7:0] cap_cmd, cap_data, cap_ext, rd_idx;
  logic cap_xv, rd_clr = 1'b0, done = 1'b0;

  always #10 clk = ~clk;

  host_nib_if dut (
    .clk(clk), .rst_n(rst_n), .hclk(hclk), .cs_n(cs_n), .bus_in(bus_in),
    .bus_out(bus_out), .bus_oe(bus_oe), .status(status), .wr_en(wr_en),
    .wr_cmd(wr_cmd), .wr_data(wr_data), .wr_ext(wr_ext), .wr_ext_vld(wr_ext_vld),
    .rd_sel(rd_sel), .rd_nib(rd_nib), .rd_pop(rd_pop));

  assign rd_nib = (rd_idx[3:0] * 4'd5) ^ {1'b0, rd_sel};

  always @(posedge clk) begin
    if (wr_en) begin
      wr_cnt <= wr_cnt + 1;
      cap_cmd <= wr_cmd; cap_data <= wr_data; cap_ext <= wr_ext; cap_xv <= wr_ext_vld;
    end
    if (rd_pop) pop_cnt <= pop_cnt + 1;
    if (rd_clr) rd_idx <= '0;
    else if (rd_pop) rd_idx <= rd_idx + 1'b1;
  end

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic begin_xfer(input logic [3:0] st);
    status = st;
    cs_n = 1'b0;
    wclk(8);
    chk(bus_oe && bus_out == st, "R2 status", {bus_oe, bus_out}, {1'b1, st});
    status = ~st;
    wclk(4);
    chk(bus_out == ~st, "R2 status tracks", bus_out, ~st);
    hclk = 1'b1; wclk(8);
    chk(!bus_oe, "R2/R10 released", bus_oe, 0);
    hclk = 1'b0; wclk(8);
  endtask

  task automatic send_nib(input logic [3:0] n);
    bus_in = n; wclk(3);
    hclk = 1'b1; wclk(8);
    hclk = 1'b0; wclk(8);
  endtask

  task automatic end_xfer();
    cs_n = 1'b1; wclk(5);
    chk(!bus_oe, "R8 release", bus_oe, 0);
    wclk(5);
  endtask

  task automatic t_write(input logic [7:0] c, input logic [7:0] d);
    int w0 = wr_cnt;
    logic [3:0] p = c[7:4] ^ c[3:0] ^ d[7:4] ^ d[3:0];
    begin_xfer(4'hA);
    send_nib(c[7:4]); send_nib(c[3:0]); send_nib(d[7:4]);
    chk(!bus_oe && wr_cnt == w0, "R10 quiet mid-write", wr_cnt - w0, 0);
    send_nib(d[3:0]);
    chk(wr_cnt == w0 + 1, "R3 one strobe", wr_cnt - w0, 1);
    chk(cap_cmd == c && cap_data == d && !cap_xv, "R3 bytes", {cap_cmd, cap_data}, {c, d});
    chk(bus_oe && bus_out == p, "R5 parity", {bus_oe, bus_out}, {1'b1, p});
    send_nib(4'h0); send_nib(4'hF);
    chk(bus_oe && bus_out == p && wr_cnt == w0 + 1, "R5 parity held", bus_out, p);
    end_xfer();
  endtask

  task automatic t_ext(input logic [7:0] d, input logic [7:0] e);
    int w0 = wr_cnt;
    logic [7:0] c = 8'h74;
    logic [3:0] p = c[7:4] ^ c[3:0] ^ d[7:4] ^ d[3:0] ^ e[7:4] ^ e[3:0];
    begin_xfer(4'h3);
    send_nib(c[7:4]); send_nib(c[3:0]); send_nib(d[7:4]); send_nib(d[3:0]);
    chk(wr_cnt == w0 && !bus_oe, "R4 no strobe at four", wr_cnt - w0, 0);
    send_nib(e[7:4]); send_nib(e[3:0]);
    chk(wr_cnt == w0 + 1 && cap_xv, "R4 strobe at six", wr_cnt - w0, 1);
    chk(cap_cmd == c && cap_data == d && cap_ext == e, "R4 bytes",
        {cap_cmd, cap_data, cap_ext}, {c, d, e});
    chk(bus_oe && bus_out == p, "R5 ext parity", bus_out, p);
    end_xfer();
  endtask

  task automatic t_abort(input int n, input logic [3:0] first);
    int w0 = wr_cnt;
    begin_xfer(4'h9);
    send_nib(first);
    for (int i = 1; i < n; i++) send_nib(4'(i * 3));
    end_xfer();
    chk(wr_cnt == w0, "R7 abort no write", wr_cnt - w0, 0);
  endtask

  task automatic t_read(input logic [2:0] s, input int n);
    int p0 = pop_cnt;
    rd_clr = 1'b1; wclk(2); rd_clr = 1'b0;
    begin_xfer(4'h6);
    send_nib({1'b1, s});
    chk(rd_sel == s, "R6 select", rd_sel, s);
    chk(bus_oe && bus_out == ({1'b0, s}), "R6 RD0", bus_out, {1'b0, s});
    for (int k = 1; k < n; k++) begin
      logic [3:0] ex = (4'(k) * 4'd5) ^ {1'b0, s};
      hclk = 1'b1; wclk(8);
      hclk = 1'b0; wclk(8);
      chk(bus_out == ex, "R6 RDk", bus_out, ex);
    end
    chk(pop_cnt == p0 + n, "R6 pop count", pop_cnt - p0, n);
    end_xfer();
  endtask

  task automatic t_idle_inert();
    int w0 = wr_cnt, p0 = pop_cnt;
    for (int i = 0; i < 8; i++) send_nib(4'(i));
    chk(wr_cnt == w0 && pop_cnt == p0 && !bus_oe, "R9 deselected inert",
        wr_cnt - w0 + pop_cnt - p0, 0);
  endtask

  initial begin
    wclk(4);
    chk(!bus_oe && !wr_en && !rd_pop, "R1 reset", {bus_oe, wr_en, rd_pop}, 0);
    rst_n = 1'b1;
    wclk(4);
    chk(!bus_oe && !wr_en && !rd_pop, "R1 after reset", {bus_oe, wr_en, rd_pop}, 0);
    t_write(8'h3A, 8'h5D);
    t_write(8'h12, 8'hF0);
    t_ext(8'h9B, 8'hE6);
    t_abort(2, 4'h2);
    t_abort(5, 4'h7);
    t_write(8'h61, 8'h0C);
    t_read(3'd5, 6);
    t_read(3'd0, 3);
    t_idle_inert();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule